// File: doc/BRIEF.md
# Peripheral Configuration Access Filter

This block guards the configuration port of a single bus peripheral that carries no security logic of its own. Every single-beat request arriving from the interconnect is tagged with a secure flag, a privileged flag, an instruction-fetch flag and a read/write direction. Two static policy bits, supplied by a central configuration bank, decide what the peripheral accepts. One bit makes the peripheral secure-only. The other makes it privileged-only.

A legal request is forwarded to the peripheral in the same cycle, with its address, direction and write data unchanged. The filter returns a response one cycle later. An illegal request never reaches the peripheral. It is answered one cycle later with an error response and zero read data. In that same cycle a one-cycle event pulse, tagged with the peripheral's fixed index, goes to an interrupt/event collector.

The configuration bank holds both policy bits clear after reset. In that state every data access passes and only instruction fetches are refused.

Top module: `cfgAccessFilter`

## Requirements
- R1: When `cfgSecOnly` is 1, a request with `reqSecure` = 0 is blocked. When `cfgSecOnly` is 0, the secure flag does not affect the decision.
- R2: When `cfgPrivOnly` is 1, a request with `reqPriv` = 0 is blocked. When `cfgPrivOnly` is 0, the privileged flag does not affect the decision.
- R3: A request with `reqFetch` = 1 is always blocked, whatever the values of the policy bits and access flags.
- R4: Each blocked request raises `evtPulse` for exactly one cycle, in the cycle its error response is returned. `evtIndex` always equals the PERIPH_INDEX parameter, which is below 128.
- R5: In reset, `rspValid`, `rspErr` and `evtPulse` are 0. With both policy bits at 0, every non-fetch request passes.
- R6: A blocked request drives `perReqValid` to 0, so a blocked write leaves peripheral storage unchanged. A blocked request gets `rspErr` = 1 and `rspRdata` = 0.
- R7: Blocked requests on consecutive cycles give `evtPulse` high on each of the consecutive response cycles, one pulse per request.
- R8: A request passes only if it satisfies both the secure check and the privileged check.
- R9: A passed request asserts `perReqValid` in its own cycle, with `perWrite`, `perAddr` and `perWdata` equal to the request fields. The filter asserts `rspValid` in the next cycle. For a passed read, `rspRdata` carries the peripheral's read data with `rspErr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSecOnly | input | 1 | Policy: secure accesses only |
| cfgPrivOnly | input | 1 | Policy: privileged accesses only |
| reqValid | input | 1 | Request strobe, one beat per cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | Access is secure |
| reqPriv | input | 1 | Access is privileged |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspErr | output | 1 | Error response |
| rspRdata | output | DATA_W | Read data, zero on error |
| perReqValid | output | 1 | Forwarded request strobe to peripheral |
| perWrite | output | 1 | Forwarded direction |
| perAddr | output | ADDR_W | Forwarded address |
| perWdata | output | DATA_W | Forwarded write data |
| perRdata | input | DATA_W | Peripheral read data, valid the cycle after a read |
| evtPulse | output | 1 | Illegal-access event pulse |
| evtIndex | output | IDX_W | Peripheral index tag for the event |

## Verification
The bench instantiates the filter with ADDR_W = 4, DATA_W = 32 and PERIPH_INDEX = 42. The 4-bit address gives a sixteen-word peripheral model whose contents the bench mirrors. That mirror shows whether a blocked write leaked through, by reading the target word back with a legal access. A non-zero index that is not a power of two makes a wrong or stuck tag visible on `evtIndex`. The vector table sweeps all policy/attribute combinations that separate the secure check, the privileged check, their AND, and fetch rejection. Directed runs then cover reset and back-to-back blocked requests.

// File: rtl/cfgFilterPkg.sv
package cfgFilterPkg;
  // Strobes handed from the decision logic to the datapath.
  typedef struct packed {
    logic fwd;      // current request is legal and goes to the peripheral
    logic rspValid; // registered: a response is due this cycle
    logic rspErr;   // registered: that response is an error
  } filterStrobes_t;
endpackage

// File: rtl/cfgFilterCtrl.sv
module cfgFilterCtrl
  import cfgFilterPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgSecOnly,
  input  logic           cfgPrivOnly,
  input  logic           reqValid,
  input  logic           reqSecure,
  input  logic           reqPriv,
  input  logic           reqFetch,
  output filterStrobes_t strobes
);
  logic secOk, privOk, legal;
  logic rspValidQ, rspErrQ;

  assign secOk  = !cfgSecOnly  || reqSecure;
  assign privOk = !cfgPrivOnly || reqPriv;
  assign legal  = secOk && privOk && !reqFetch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rspErrQ   <= 1'b0;
    end else begin
      rspValidQ <= reqValid;
      rspErrQ   <= reqValid && !legal;
    end
  end

  assign strobes.fwd      = reqValid && legal;
  assign strobes.rspValid = rspValidQ;
  assign strobes.rspErr   = rspErrQ;

  // R1: nonsecure access to a secure-only peripheral errs next cycle
  p_sec_block_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && cfgSecOnly && !reqSecure |=> strobes.rspErr);
  // R2: unprivileged access to a privileged-only peripheral errs next cycle
  p_priv_block_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && cfgPrivOnly && !reqPriv |=> strobes.rspErr);
  // R3: fetches always err
  p_fetch_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqFetch |=> strobes.rspErr);
  // R9: response exactly one cycle after each request
  p_rsp_timing_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> strobes.rspValid);
endmodule

// File: rtl/cfgFilterData.sv
module cfgFilterData
  import cfgFilterPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  filterStrobes_t    strobes,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] perRdata,
  output logic              perReqValid,
  output logic              perWrite,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWdata,
  output logic [DATA_W-1:0] rspRdata
);
  localparam logic [DATA_W-1:0] ZERO_DATA = '0;

  assign perReqValid = strobes.fwd;
  assign perWrite    = reqWrite;
  assign perAddr     = reqAddr;
  assign perWdata    = reqWdata;

  always_comb begin
    if (strobes.rspValid && !strobes.rspErr) rspRdata = perRdata;
    else                                     rspRdata = ZERO_DATA;
  end

  // R6: an error response never carries data
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rspErr |-> rspRdata == ZERO_DATA);
endmodule

// File: rtl/cfgAccessFilter.sv
module cfgAccessFilter
  import cfgFilterPkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 7,
  parameter int PERIPH_INDEX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSecOnly,
  input  logic              cfgPrivOnly,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic              reqPriv,
  input  logic              reqFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              perReqValid,
  output logic              perWrite,
  output logic [ADDR_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWdata,
  input  logic [DATA_W-1:0] perRdata,
  output logic              evtPulse,
  output logic [IDX_W-1:0]  evtIndex
);
  localparam logic [IDX_W-1:0] INDEX_TAG = IDX_W'(PERIPH_INDEX);

  filterStrobes_t strobes;

  cfgFilterCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgSecOnly(cfgSecOnly), .cfgPrivOnly(cfgPrivOnly),
    .reqValid(reqValid), .reqSecure(reqSecure), .reqPriv(reqPriv),
    .reqFetch(reqFetch), .strobes(strobes)
  );

  cfgFilterData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .perRdata(perRdata), .perReqValid(perReqValid), .perWrite(perWrite),
    .perAddr(perAddr), .perWdata(perWdata), .rspRdata(rspRdata)
  );

  assign rspValid = strobes.rspValid;
  assign rspErr   = strobes.rspErr;
  assign evtPulse = strobes.rspErr;
  assign evtIndex = INDEX_TAG;

  // R6/R3: fetches never reach the peripheral
  p_fetch_not_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqFetch |-> !perReqValid);
  // R4: every error response carries an event pulse
  p_evt_with_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr |-> evtPulse);
  // R7: a blocked request following a blocked request keeps the pulse high
  p_b2b_evt_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse && reqValid && reqFetch |=> evtPulse);
  // R5: policy clear, non-fetch request passes
  p_open_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqFetch && !cfgSecOnly && !cfgPrivOnly |-> perReqValid);
  // R8: a forwarded request met both checks
  p_and_r8: assert property (@(posedge clk) disable iff (!rstN)
    perReqValid |-> (!cfgSecOnly || reqSecure) && (!cfgPrivOnly || reqPriv));
endmodule

// File: tb/cfgAccessFilter_bench.sv
module cfgAccessFilter_bench;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 7;
  localparam int PIDX   = 42;
  localparam int NVEC   = 16;

  // {cfgSec, cfgPriv, sec, priv, fetch, write, expErr}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0000010, 7'b0000000, 7'b1000011, 7'b1010010,
    7'b0100011, 7'b0101010, 7'b1110001, 7'b1101001,
    7'b1111000, 7'b0000101, 7'b1111101, 7'b1011000,
    7'b0111010, 7'b0011000, 7'b1001001, 7'b0110001
  };

  logic clk = 0, rstN = 0;
  logic cfgSecOnly = 0, cfgPrivOnly = 0;
  logic reqValid = 0, reqWrite = 0, reqSecure = 0, reqPriv = 0, reqFetch = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic rspValid, rspErr, perReqValid, perWrite, evtPulse;
  logic [DATA_W-1:0] rspRdata, perWdata, perRdata;
  logic [ADDR_W-1:0] perAddr;
  logic [IDX_W-1:0] evtIndex;

  logic [DATA_W-1:0] perMem [16];
  logic [DATA_W-1:0] shadow [16];
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfgAccessFilter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
                    .PERIPH_INDEX(PIDX)) u_cfgAccessFilter (
    .clk(clk), .rstN(rstN), .cfgSecOnly(cfgSecOnly), .cfgPrivOnly(cfgPrivOnly),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqPriv(reqPriv), .reqFetch(reqFetch), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .perReqValid(perReqValid), .perWrite(perWrite),
    .perAddr(perAddr), .perWdata(perWdata), .perRdata(perRdata),
    .evtPulse(evtPulse), .evtIndex(evtIndex)
  );

  // Peripheral model: synchronous read, one cycle latency
  initial begin
    for (int k = 0; k < 16; k++) begin
      perMem[k] = DATA_W'(k * 32'h11);
      shadow[k] = DATA_W'(k * 32'h11);
    end
    perRdata = '0;
  end
  always @(posedge clk) begin
    if (perReqValid) begin
      if (perWrite) perMem[perAddr] <= perWdata;
      else          perRdata <= perMem[perAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; checks forwarding before the edge and response after it.
  task automatic access(input logic cs, input logic cp, input logic s, input logic p,
                        input logic f, input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic expErr);
    logic [DATA_W-1:0] expData;
    cfgSecOnly = cs; cfgPrivOnly = cp; reqSecure = s; reqPriv = p;
    reqFetch = f; reqWrite = w; reqAddr = a; reqWdata = d; reqValid = 1;
    #1;
    chk(perReqValid == !expErr, "R1/R2/R3/R8 forward", DATA_W'(perReqValid), DATA_W'(!expErr));
    if (!expErr)
      chk(perWrite == w && perAddr == a && perWdata == d, "R9 fields",
          perWdata, d);
    expData = (expErr || w) ? '0 : shadow[a];
    if (!expErr && w) shadow[a] = d;
    @(negedge clk);
    reqValid = 0;
    chk(rspValid == 1'b1, "R9 rspValid", DATA_W'(rspValid), 1);
    chk(rspErr == expErr, "R6 rspErr", DATA_W'(rspErr), DATA_W'(expErr));
    chk(evtPulse == expErr, "R4 evtPulse", DATA_W'(evtPulse), DATA_W'(expErr));
    if (!w || expErr) chk(rspRdata == expData, "R6/R9 rdata", rspRdata, expData);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    chk(rspValid == 0 && rspErr == 0 && evtPulse == 0, "R5 reset",
        {29'd0, rspValid, rspErr, evtPulse}, 0);
    chk(evtIndex == IDX_W'(PIDX), "R4 index", DATA_W'(evtIndex), PIDX);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1],
             ADDR_W'(i / 2), 32'hA500_0000 | i, VEC[i][0]);
    end

    // R6: blocked write to word 9 leaves it unchanged, then legal read
    access(1, 0, 0, 1, 0, 1, 4'd9, 32'hDEAD_BEEF, 1);
    access(0, 0, 0, 0, 0, 0, 4'd9, '0, 0);
    // R5: open policy, unprivileged nonsecure write and read pass
    access(0, 0, 0, 0, 0, 1, 4'd12, 32'h1234_5678, 0);
    access(0, 0, 0, 0, 0, 0, 4'd12, '0, 0);
    // R3: fetch with everything permissive still fails
    access(0, 0, 1, 1, 1, 0, 4'd3, '0, 1);

    // R7: three blocked fetches back to back
    cfgSecOnly = 0; cfgPrivOnly = 0; reqFetch = 1; reqWrite = 0; reqValid = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(evtPulse == 1 && rspErr == 1, "R7 b2b pulse", DATA_W'(evtPulse), 1);
    end
    reqValid = 0; reqFetch = 0;
    @(negedge clk);
    chk(evtPulse == 0, "R7 pulse ends", DATA_W'(evtPulse), 0);
    chk(rspValid == 0, "R9 idle", DATA_W'(rspValid), 0);

    // R5: reset mid-stream clears response
    reqValid = 1; reqFetch = 1;
    @(negedge clk);
    rstN = 0; reqValid = 0; reqFetch = 0;
    @(negedge clk);
    chk(rspValid == 0 && evtPulse == 0, "R5 reset clears", DATA_W'(evtPulse), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule